// File: doc/BRIEF.md
# PS/2 Device-Side Byte Transmitter

This block sends one byte from the device end of a PS/2 link (the keyboard or mouse side) to the host. Both bus lines are open-drain. The block reads each line through a two-flop synchronizer, and it pulls a line low by raising a drive-enable output for that line. The device generates the clock itself. Its bit timing is built from a microsecond tick, which is prescaled from the system clock by the `CLK_HZ` parameter.

A transfer begins with a one-cycle `start` strobe. On that strobe the byte on `tx_byte` is latched. The block then checks that the bus is free. It samples the clock line twice, about 20 µs apart, and then samples the data line once. If the bus is free, it sends an 11-bit frame. At the end of each bit it samples the clock line to find out whether the host has stopped the transfer.

Every attempt ends the same way. Both lines are released, a guard time runs, and then a one-cycle `done` pulse is given. At that point `status` holds the result code and `host_req` shows whether the host broke into the frame.

Top module: `ps2_dev_tx`

## Requirements
- R1: If the synchronized clock line is low at the first check (the cycle after `start` is accepted), or again at the second check about 20 µs later, the attempt ends. It ends with status 0x90, with no clock pulse and with no data drive.
- R2: If both clock checks pass but the data line is low, the attempt ends with status 0x90. There is no clock pulse and no data drive, and `host_req` stays 0.
- R3: Each bit cell follows a fixed order. First the data line is set to the bit value and held for 10 µs. Then the clock is driven low for 38 µs. Then the clock is released for 22 µs. The data drive does not change while the clock is driven low.
- R4: A frame is 11 clock pulses. The data value seen at each pulse is, in order: a start bit of 0, the eight data bits least significant first, a parity bit, and a stop bit of 1.
- R5: The parity bit is the low bit of (1 + the number of ones in the byte). This makes the count of ones in the data and parity bits together odd.
- R6: An extra 2 µs is inserted between the end of the start-bit cell and the data setup of the first data bit.
- R7: For the start bit, the data bits and the parity bit, the clock line is sampled at the end of the cell. If it reads low, no further pulse is sent, both lines are released, `host_req` is set to 1 and the status is 0x88. The stop bit is not sampled in this way. Once the stop-bit cell is complete, the status is always 0x00.
- R8: On every exit path both drive enables are 0. A guard time of 38 µs then runs before `done` is raised, and `done` lasts exactly one cycle.
- R9: `host_req` is cleared when a `start` is accepted.
- R10: After reset, `busy`, `done`, `host_req` and both drive enables are 0. `busy` is 1 from the cycle after an accepted `start` until `done` is given. A `start` that arrives while `busy` is 1 is ignored, and so is any change on `tx_byte` at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to send `tx_byte` |
| tx_byte | input | 8 | Byte to send; latched when `start` is accepted |
| ps2_clk_i | input | 1 | Raw level of the bus clock line |
| ps2_dat_i | input | 1 | Raw level of the bus data line |
| ps2_clk_oe | output | 1 | 1 pulls the bus clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the bus data line low |
| busy | output | 1 | A transfer attempt is in progress |
| done | output | 1 | One-cycle pulse at the end of an attempt |
| status | output | 8 | Result: 0x00 sent, 0x88 host inhibit, 0x90 bus not free |
| host_req | output | 1 | Host broke into the last frame |

## Verification
The bench checks the three ways an attempt can end. In the first, the host already holds the clock low before `start`, or pulls it low during the 20 µs wait. A design that samples the clock only once would then drive the bus anyway. In the second, the data line is low, and a design that got this wrong would clock out a frame instead of returning 0x90. In the third, the host pulls the clock low during the start bit or in the middle of the data bits. A late abort would show up as extra clock pulses. A missing flag would show up as `host_req` staying at 0.

The bench also pulls the clock low right after the stop bit. This catches a design that samples the stop bit like the other bits and reports 0x88. Bytes with no ones, all ones and a single one catch a parity of the wrong sense. The cell timing is measured: the low phase, the extra 2 µs after the start bit, and the guard time before `done`. A strobe sent in mid-frame, with a different byte on `tx_byte`, must leave the frame unchanged and must not start a second frame.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

  localparam int FRAME_BITS = 11;

  localparam logic [7:0] STAT_SENT    = 8'h00;
  localparam logic [7:0] STAT_INHIBIT = 8'h88;
  localparam logic [7:0] STAT_BUSBUSY = 8'h90;

  typedef enum logic [3:0] {
    TX_IDLE,
    TX_CHK_A,
    TX_WAIT,
    TX_CHK_B,
    TX_SETUP,
    TX_LOW,
    TX_HIGH,
    TX_GAP,
    TX_GUARD
  } tx_state_e;

  // Low bit of (1 + number of ones): odd parity over data plus parity bit.
  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d);
  endfunction

  // Bit 0 leaves first: start, data LSB first, parity, stop.
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] d);
    return {1'b1, odd_par(d), d, 1'b0};
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);

  // Both lines idle high, so the chains reset to 1.
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/ps2tx_timer.sv
module ps2tx_timer #(
  parameter int CYC_PER_US = 8,
  parameter int US_W       = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  output logic            expired
);

  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYC_PER_US - 1);

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_q;
  logic             us_tick;

  // The prescaler restarts on every load, so a delay is a whole number of microseconds.
  assign us_tick = (pre_q == '0);
  assign expired = (us_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (load) begin
      pre_q <= PRE_TOP;
      us_q  <= load_us;
    end else if (!expired) begin
      if (us_tick) begin
        pre_q <= PRE_TOP;
        us_q  <= us_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired); // R3

endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
  import ps2tx_pkg::*;
#(
  parameter int CLK_HZ       = 8_000_000,
  parameter int IDLE_GAP_US  = 20,
  parameter int SETUP_US     = 10,
  parameter int LOW_US       = 38,
  parameter int HIGH_US      = 22,
  parameter int START_GAP_US = 2,
  parameter int GUARD_US     = 38,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       ps2_clk_oe,
  output logic       ps2_dat_oe,
  output logic       busy,
  output logic       done,
  output logic [7:0] status,
  output logic       host_req
);

  localparam int CYC_PER_US = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int MAX_US = max_of(max_of(max_of(IDLE_GAP_US, SETUP_US), max_of(LOW_US, HIGH_US)),
                                 max_of(START_GAP_US, GUARD_US));
  localparam int US_W  = $clog2(MAX_US + 1);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  // Synchronized bus levels
  logic [1:0] line_s;
  logic       clk_s, dat_s;

  ps2tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    ({ps2_dat_i, ps2_clk_i}),
    .synced (line_s)
  );
  assign clk_s = line_s[0];
  assign dat_s = line_s[1];

  // Delay timer
  logic            tmr_load;
  logic [US_W-1:0] tmr_us;
  logic            tmr_exp;

  ps2tx_timer #(.CYC_PER_US(CYC_PER_US), .US_W(US_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_us (tmr_us),
    .expired (tmr_exp)
  );

  // State
  tx_state_e             state_q, state_d;
  logic [FRAME_BITS-1:0] frame_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  dat_oe_q;
  logic [7:0]            status_q;
  logic                  host_req_q;
  logic                  done_q;

  // Named internal events
  logic accept_w;      // start taken, byte latched
  logic bus_busy_w;    // exit with 0x90
  logic first_bit_w;   // bus free, start-bit drive begins
  logic next_bit_w;    // move to the next frame bit
  logic bit_sample_w;  // end-of-cell clock sample
  logic inhibit_w;     // exit with 0x88
  logic frame_ok_w;    // exit with 0x00
  logic finish_w;      // guard time over

  always_comb begin
    state_d      = state_q;
    tmr_load     = 1'b0;
    tmr_us       = '0;
    accept_w     = 1'b0;
    bus_busy_w   = 1'b0;
    first_bit_w  = 1'b0;
    next_bit_w   = 1'b0;
    bit_sample_w = 1'b0;
    inhibit_w    = 1'b0;
    frame_ok_w   = 1'b0;
    finish_w     = 1'b0;
    unique case (state_q)
      TX_IDLE: if (start) begin
        accept_w = 1'b1;
        state_d  = TX_CHK_A;
      end
      TX_CHK_A: begin
        tmr_load = 1'b1;
        if (!clk_s) begin
          bus_busy_w = 1'b1;
          tmr_us     = US_W'(GUARD_US);
          state_d    = TX_GUARD;
        end else begin
          tmr_us  = US_W'(IDLE_GAP_US);
          state_d = TX_WAIT;
        end
      end
      TX_WAIT: if (tmr_exp) state_d = TX_CHK_B;
      TX_CHK_B: begin
        tmr_load = 1'b1;
        if (!clk_s || !dat_s) begin
          bus_busy_w = 1'b1;
          tmr_us     = US_W'(GUARD_US);
          state_d    = TX_GUARD;
        end else begin
          first_bit_w = 1'b1;
          tmr_us      = US_W'(SETUP_US);
          state_d     = TX_SETUP;
        end
      end
      TX_SETUP: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_us   = US_W'(LOW_US);
        state_d  = TX_LOW;
      end
      TX_LOW: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_us   = US_W'(HIGH_US);
        state_d  = TX_HIGH;
      end
      TX_HIGH: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (idx_q == LAST_IDX) begin
          frame_ok_w = 1'b1;
          tmr_us     = US_W'(GUARD_US);
          state_d    = TX_GUARD;
        end else begin
          bit_sample_w = 1'b1;
          if (!clk_s) begin
            inhibit_w = 1'b1;
            tmr_us    = US_W'(GUARD_US);
            state_d   = TX_GUARD;
          end else if (idx_q == '0) begin
            tmr_us  = US_W'(START_GAP_US);
            state_d = TX_GAP;
          end else begin
            next_bit_w = 1'b1;
            tmr_us     = US_W'(SETUP_US);
            state_d    = TX_SETUP;
          end
        end
      end
      TX_GAP: if (tmr_exp) begin
        next_bit_w = 1'b1;
        tmr_load   = 1'b1;
        tmr_us     = US_W'(SETUP_US);
        state_d    = TX_SETUP;
      end
      TX_GUARD: if (tmr_exp) begin
        finish_w = 1'b1;
        state_d  = TX_IDLE;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TX_IDLE;
      frame_q    <= '0;
      idx_q      <= '0;
      dat_oe_q   <= 1'b0;
      status_q   <= STAT_SENT;
      host_req_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish_w;
      if (accept_w) begin
        frame_q    <= build_frame(tx_byte);
        idx_q      <= '0;
        host_req_q <= 1'b0;
      end
      if (first_bit_w) dat_oe_q <= ~frame_q[0];
      if (next_bit_w) begin
        idx_q    <= idx_q + 1'b1;
        dat_oe_q <= ~frame_q[idx_q + 1'b1];
      end
      if (bus_busy_w) status_q <= STAT_BUSBUSY;
      if (frame_ok_w) begin
        status_q <= STAT_SENT;
        dat_oe_q <= 1'b0;
      end
      if (inhibit_w) begin
        status_q   <= STAT_INHIBIT;
        host_req_q <= 1'b1;
        dat_oe_q   <= 1'b0;
      end
    end
  end

  assign ps2_clk_oe = (state_q == TX_LOW);
  assign ps2_dat_oe = dat_oe_q;
  assign busy       = (state_q != TX_IDLE);
  assign done       = done_q;
  assign status     = status_q;
  assign host_req   = host_req_q;

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ps2_clk_oe && !ps2_dat_oe)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DAT_HELD_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ps2_clk_oe && $past(ps2_clk_oe)) |-> $stable(ps2_dat_oe)); // R3
  AST_BUSBUSY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy_w |-> (!ps2_clk_oe && !ps2_dat_oe)); // R1
  AST_STOP_BIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok_w |-> !ps2_dat_oe); // R4
  AST_INHIBIT_FLAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && host_req) |-> (status == STAT_INHIBIT)); // R7
  AST_BYTE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(frame_q)); // R10
  AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bit_sample_w |-> !ps2_clk_oe); // R7

endmodule

// File: tb/test_ps2_dev_tx.sv
module test_ps2_dev_tx;

  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 2_000_000;
  localparam int CYC        = TB_CLK_HZ / 1_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic ps2_clk_oe, ps2_dat_oe, busy, done, host_req;
  logic [7:0] status;
  logic host_clk_low = 1'b0;
  logic host_dat_low = 1'b0;
  logic bus_clk, bus_dat;

  assign bus_clk = ~(ps2_clk_oe | host_clk_low);
  assign bus_dat = ~(ps2_dat_oe | host_dat_low);

  always #(CLK_PERIOD / 2) clk = ~clk;

  ps2_dev_tx #(.CLK_HZ(TB_CLK_HZ)) i_ps2_dev_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
    .ps2_clk_i(bus_clk), .ps2_dat_i(bus_dat),
    .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe),
    .busy(busy), .done(done), .status(status), .host_req(host_req)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Cycle counter and host-side capture
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int pulse_cnt = 0;
  int inhibit_after = 0;
  logic [15:0] cap_bits;
  int rise_t [16];
  int fall_t [16];
  int done_t = 0;
  int done_cnt = 0;

  always @(posedge ps2_clk_oe) begin
    if (pulse_cnt < 16) begin
      cap_bits[pulse_cnt] = bus_dat;
      rise_t[pulse_cnt] = cyc;
    end
    pulse_cnt++;
  end

  always @(negedge ps2_clk_oe) begin
    if (pulse_cnt >= 1 && pulse_cnt <= 16) fall_t[pulse_cnt-1] = cyc;
    if (inhibit_after != 0 && pulse_cnt == inhibit_after) begin
      repeat (4) @(posedge clk);
      host_clk_low = 1'b1;
    end
  end

  // Scoreboard
  typedef struct {
    logic [7:0]  st;
    bit          hr;
    int          pulses;
    logic [10:0] frame;
    string       tag;
  } exp_t;
  exp_t exp_q [$];

  function automatic logic [10:0] ref_frame(input logic [7:0] b);
    int ones = 1;
    for (int i = 0; i < 8; i++) ones += b[i];
    return {1'b1, 1'(ones % 2), b, 1'b0};
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      done_t = cyc;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(status === e.st, e.tag, "status", status, e.st);
        chk(host_req === e.hr, "R7", "host_req at done", host_req, e.hr);
        chk(pulse_cnt == e.pulses, "R4", "clock pulse count", pulse_cnt, e.pulses);
        for (int i = 0; i < 11; i++)
          if (i < e.pulses && i < pulse_cnt)
            chk(cap_bits[i] === e.frame[i], (i == 9) ? "R5" : "R4", $sformatf("frame bit %0d", i),
                cap_bits[i], e.frame[i]);
        chk(!ps2_clk_oe && !ps2_dat_oe, "R8", "lines released at done",
            {ps2_clk_oe, ps2_dat_oe}, 0);
      end
      done_cnt++;
    end
  end

  task automatic send(input logic [7:0] b, input logic [7:0] st, input bit hr,
                      input int pulses, input int inh, input string tag);
    exp_t e;
    int n;
    e.st = st; e.hr = hr; e.pulses = pulses; e.frame = ref_frame(b); e.tag = tag;
    exp_q.push_back(e);
    pulse_cnt = 0;
    cap_bits = '0;
    inhibit_after = inh;
    n = done_cnt;
    @(negedge clk);
    tx_byte = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (done_cnt != n);
    if (inh != 0) host_clk_low = 1'b0;
    inhibit_after = 0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(busy === 1'b0, "R10", "busy after reset", busy, 0);
    chk(done === 1'b0, "R10", "done after reset", done, 0);
    chk(host_req === 1'b0, "R10", "host_req after reset", host_req, 0);
    chk(!ps2_clk_oe && !ps2_dat_oe, "R10", "drives after reset", {ps2_clk_oe, ps2_dat_oe}, 0);

    // Plain frame and timing (R3, R6, R8)
    send(8'hA5, 8'h00, 1'b0, 11, 0, "R7");
    begin
      int low_d, g01, g12, guard;
      low_d = fall_t[0] - rise_t[0];
      chk(low_d >= 38*CYC-1 && low_d <= 38*CYC+3, "R3", "clock low phase cycles", low_d, 38*CYC+1);
      g01 = rise_t[1] - rise_t[0];
      g12 = rise_t[2] - rise_t[1];
      chk((g01 - g12) >= 2*CYC-1 && (g01 - g12) <= 2*CYC+3, "R6", "extra gap after start bit",
          g01 - g12, 2*CYC+1);
      chk(g12 >= 70*CYC && g12 <= 70*CYC+6, "R3", "bit cell period", g12, 70*CYC+3);
      guard = done_t - fall_t[10];
      chk(guard >= 60*CYC && guard <= 60*CYC+5, "R8", "release to done", guard, 60*CYC+2);
    end

    // Parity patterns (R5)
    send(8'h00, 8'h00, 1'b0, 11, 0, "R5");
    send(8'hFF, 8'h00, 1'b0, 11, 0, "R5");
    send(8'h01, 8'h00, 1'b0, 11, 0, "R5");
    send(8'h80, 8'h00, 1'b0, 11, 0, "R5");

    // Clock held low before start (R1)
    host_clk_low = 1'b1;
    send(8'h12, 8'h90, 1'b0, 0, 0, "R1");
    host_clk_low = 1'b0;

    // Clock pulled low during the idle wait (R1, second sample)
    fork
      send(8'h34, 8'h90, 1'b0, 0, 0, "R1");
      begin
        repeat (10) @(negedge clk);
        host_clk_low = 1'b1;
      end
    join
    host_clk_low = 1'b0;

    // Data low: host wants to send (R2)
    host_dat_low = 1'b1;
    send(8'h56, 8'h90, 1'b0, 0, 0, "R2");
    host_dat_low = 1'b0;

    // Inhibit mid-byte and at the start bit (R7)
    send(8'h9C, 8'h88, 1'b1, 3, 3, "R7");
    chk(host_req === 1'b1, "R7", "host_req held after inhibit", host_req, 1);

    // host_req cleared on the next accepted start (R9)
    fork
      send(8'h5A, 8'h00, 1'b0, 11, 0, "R7");
      begin
        repeat (4) @(negedge clk);
        chk(host_req === 1'b0, "R9", "host_req cleared on start", host_req, 0);
        chk(busy === 1'b1, "R10", "busy during attempt", busy, 1);
      end
    join

    send(8'h77, 8'h88, 1'b1, 1, 1, "R7");

    // Inhibit after the stop bit is not an abort (R7)
    send(8'hC4, 8'h00, 1'b0, 11, 11, "R7");

    // Start during busy is ignored (R10)
    fork
      send(8'h3C, 8'h00, 1'b0, 11, 0, "R10");
      begin
        repeat (300) @(negedge clk);
        tx_byte = 8'hC3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    repeat (60) @(negedge clk);
    chk(busy === 1'b0, "R10", "no second attempt", busy, 0);
    chk(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule